// File: doc/BRIEF.md
# 64-bit Adder with Split Carry and Overflow Flags

This block is a one-stage integer add/subtract unit for a fixed-point execution pipeline. Each accepted operation yields a sum plus a set of status flags: carry and overflow, each reported at both the full-width boundary and the half-width (32-bit) boundary, a sticky summary-overflow bit, and a 4-bit condition field. Every flag group comes with its own write-enable. The surrounding core can therefore treat each status bit as an independent register and rename or track it on its own.

The operation is chosen by a 3-bit code. Along with it come an overflow-enable bit and a record bit. The operands are A, a second operand B (which may carry an immediate), the current summary-overflow bit and the current carry bit. Subtraction is done as B + ~A + 1 and negation as ~A + 1, so all variants share one adder and one carry chain. Results are registered: a request accepted on one rising edge is visible on the next.

Top module: `addx_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for exactly that cycle. The result is A+B for codes 0 and 1, A+B+`ca_in` for codes 2 and 6, B+~A+1 for codes 3 and 4, and ~A+1 for code 5, all modulo 2^64. `res_we` is high for every code except 7.
- R2: Opcode values: 0 plain add, 1 add writing carry, 2 add-with-carry-in writing carry, 3 reverse subtract, 4 reverse subtract writing carry, 5 negate, 6 add-with-carry-in whose carry-out feeds the overflow pair, 7 signed compare.
- R3: For codes 1, 2 and 4, `ca_we` is high, `ca_out[1]` is the carry out of bit 63 and `ca_out[0]` the carry out of bit 31. For all other codes `ca_we` is low.
- R4: For codes 0 to 5 with `oe` high, `ov_we` is high. `ov_out[1]` is the carry into bit 63 XOR the carry out of bit 63, and `ov_out[0]` is the same test taken at bit 31.
- R5: For codes 0 to 5 with `oe` low, `ov_we` and `so_we` are both low.
- R6: Code 6 writes the overflow pair whatever `oe` is: `ov_out[1]` is the carry out of bit 63 and `ov_out[0]` the carry out of bit 31. It never writes the carry pair.
- R7: `so_we` always equals `ov_we`. When written, `so_out` is `so_in` OR `ov_out[1]`, so the bit is sticky.
- R8: With `rc` high and any code except 7, `cr0_we` is high and `cr0` is {negative, positive, zero, summary} (bits 3..0). The first three come from the signed result. The summary bit is the updated `so_out`. With `rc` low and a code other than 7, `cr0_we` is low.
- R9: Code 7 writes neither summary, overflow, carry nor the result. It always writes `cr0`, as {A<B, A>B, A==B, `so_in`}, with A and B compared as signed values.
- R10: Negate (code 5) ignores both B and `ca_in`.
- R11: After reset, `out_valid`, every write-enable and every data output are zero.
- R12: In any cycle where `out_valid` is low, all write-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| op | input | 3 | Operation code (R2) |
| oe | input | 1 | Overflow enable for codes 0-5 |
| rc | input | 1 | Record enable for the condition field |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B or immediate |
| so_in | input | 1 | Current summary-overflow bit |
| ca_in | input | 1 | Current carry bit |
| out_valid | output | 1 | Result valid |
| res | output | 64 | Sum |
| res_we | output | 1 | Result write-enable |
| cr0 | output | 4 | Condition field {neg, pos, zero, summary} |
| cr0_we | output | 1 | Condition field write-enable |
| so_out | output | 1 | New summary-overflow bit |
| so_we | output | 1 | Summary write-enable |
| ca_out | output | 2 | {carry64, carry32} |
| ca_we | output | 1 | Carry pair write-enable |
| ov_out | output | 2 | {overflow64, overflow32} |
| ov_we | output | 1 | Overflow pair write-enable |

## Verification
Every result, flag and write-enable passes through exactly one register, so its value is due in the cycle after the edge that accepted the request. The bench drives each request on a falling edge, lets one rising edge capture it, and reads the outputs on the next falling edge, halfway between edges. It also samples the following idle cycle to confirm that the write-enables have dropped. Data fields are compared only when the expected write-enable is high; the write-enables themselves are compared on every check.

// File: rtl/addx_pkg.sv
`timescale 1ns/1ps
package addx_pkg;

    typedef enum logic [2:0] {
        OP_ADD      = 3'd0,
        OP_ADD_CA   = 3'd1,
        OP_ADD_CIN  = 3'd2,
        OP_RSUB     = 3'd3,
        OP_RSUB_CA  = 3'd4,
        OP_NEG      = 3'd5,
        OP_ADD_OVC  = 3'd6,
        OP_CMP      = 3'd7
    } addx_op_e;

    // operand shaping and flag policy derived from the opcode
    typedef struct packed {
        logic invert_a;
        logic invert_b;
        logic zero_b;
        logic use_ci;
        logic force_ci;
        logic writes_ca;
        logic oe_ov;
        logic ov_is_carry;
        logic is_cmp;
    } addx_ctl_t;

    // raw carry-chain observations
    typedef struct packed {
        logic co;
        logic co_half;
        logic ovf;
        logic ovf_half;
    } addx_raw_t;

    // flag values and their enables
    typedef struct packed {
        logic       res_we;
        logic [3:0] cr0;
        logic       cr0_we;
        logic       so;
        logic       so_we;
        logic       ca;
        logic       ca32;
        logic       ca_we;
        logic       ov;
        logic       ov32;
        logic       ov_we;
    } addx_wr_t;

    function automatic addx_ctl_t addx_decode(input logic [2:0] code);
        addx_ctl_t c;
        c = '0;
        unique case (addx_op_e'(code))
            OP_ADD:     begin c.oe_ov = 1'b1; end
            OP_ADD_CA:  begin c.oe_ov = 1'b1; c.writes_ca = 1'b1; end
            OP_ADD_CIN: begin c.oe_ov = 1'b1; c.writes_ca = 1'b1; c.use_ci = 1'b1; end
            OP_RSUB:    begin c.oe_ov = 1'b1; c.invert_a = 1'b1; c.force_ci = 1'b1; end
            OP_RSUB_CA: begin c.oe_ov = 1'b1; c.invert_a = 1'b1; c.force_ci = 1'b1;
                              c.writes_ca = 1'b1; end
            OP_NEG:     begin c.oe_ov = 1'b1; c.invert_a = 1'b1; c.force_ci = 1'b1;
                              c.zero_b = 1'b1; end
            OP_ADD_OVC: begin c.use_ci = 1'b1; c.ov_is_carry = 1'b1; end
            OP_CMP:     begin c.invert_b = 1'b1; c.force_ci = 1'b1; c.is_cmp = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addx_operand_mux.sv
`timescale 1ns/1ps
module addx_operand_mux #(
    parameter int WIDTH = 64
) (
    input  logic             invert_a,
    input  logic             invert_b,
    input  logic             zero_b,
    input  logic             use_ci,
    input  logic             force_ci,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y,
    output logic             cin
);
    always_comb begin
        x   = invert_a ? ~a : a;
        if (zero_b)
            y = '0;
        else
            y = invert_b ? ~b : b;
        cin = force_ci | (use_ci & ci);
    end
endmodule

// File: rtl/addx_core.sv
`timescale 1ns/1ps
module addx_core
    import addx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output addx_raw_t        raw
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0]   wide;
    logic [WIDTH-1:0] carry_into;

    always_comb begin
        wide       = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum        = wide[WIDTH-1:0];
        // carry entering each bit position
        carry_into = x ^ y ^ wide[WIDTH-1:0];
        raw.co       = wide[WIDTH];
        raw.co_half  = carry_into[HALF];
        raw.ovf      = wide[WIDTH] ^ carry_into[WIDTH-1];
        raw.ovf_half = carry_into[HALF] ^ carry_into[HALF-1];
    end
endmodule

// File: rtl/addx_flags.sv
`timescale 1ns/1ps
module addx_flags
    import addx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             writes_ca,
    input  logic             oe_ov,
    input  logic             ov_is_carry,
    input  logic             is_cmp,
    input  addx_raw_t        raw,
    input  logic [WIDTH-1:0] sum,
    input  logic             oe,
    input  logic             rc,
    input  logic             so_in,
    output addx_wr_t         wr
);
    logic neg_flag;
    logic zero_flag;

    always_comb begin
        wr        = '0;
        wr.ov_we  = ov_is_carry | (oe_ov & oe);
        wr.ov     = ov_is_carry ? raw.co      : raw.ovf;
        wr.ov32   = ov_is_carry ? raw.co_half : raw.ovf_half;
        wr.so_we  = wr.ov_we;
        wr.so     = so_in | (wr.ov_we & wr.ov);
        wr.ca_we  = writes_ca;
        wr.ca     = raw.co;
        wr.ca32   = raw.co_half;
        // a compare looks at A-B, so the true sign needs the overflow correction
        neg_flag  = is_cmp ? (sum[WIDTH-1] ^ raw.ovf) : sum[WIDTH-1];
        zero_flag = ~|sum;
        wr.cr0    = {neg_flag, ~neg_flag & ~zero_flag, zero_flag, wr.so};
        wr.cr0_we = is_cmp | rc;
        wr.res_we = ~is_cmp;
    end
endmodule

// File: rtl/addx_unit.sv
`timescale 1ns/1ps
module addx_unit
    import addx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic             oe,
    input  logic             rc,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             so_in,
    input  logic             ca_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] res,
    output logic             res_we,
    output logic [3:0]       cr0,
    output logic             cr0_we,
    output logic             so_out,
    output logic             so_we,
    output logic [1:0]       ca_out,
    output logic             ca_we,
    output logic [1:0]       ov_out,
    output logic             ov_we
);
    addx_ctl_t        ctl;
    logic [WIDTH-1:0] x, y, sum;
    logic             cin;
    addx_raw_t        raw;
    addx_wr_t         wr;

    assign ctl = addx_decode(op);

    addx_operand_mux #(.WIDTH(WIDTH)) u_mux (
        .invert_a (ctl.invert_a),
        .invert_b (ctl.invert_b),
        .zero_b   (ctl.zero_b),
        .use_ci   (ctl.use_ci),
        .force_ci (ctl.force_ci),
        .a        (opa),
        .b        (opb),
        .ci       (ca_in),
        .x        (x),
        .y        (y),
        .cin      (cin)
    );

    addx_core #(.WIDTH(WIDTH)) u_core (
        .x   (x),
        .y   (y),
        .cin (cin),
        .sum (sum),
        .raw (raw)
    );

    addx_flags #(.WIDTH(WIDTH)) u_flags (
        .writes_ca   (ctl.writes_ca),
        .oe_ov       (ctl.oe_ov),
        .ov_is_carry (ctl.ov_is_carry),
        .is_cmp      (ctl.is_cmp),
        .raw         (raw),
        .sum         (sum),
        .oe          (oe),
        .rc          (rc),
        .so_in       (so_in),
        .wr          (wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
            res_we    <= 1'b0;
            cr0       <= '0;
            cr0_we    <= 1'b0;
            so_out    <= 1'b0;
            so_we     <= 1'b0;
            ca_out    <= '0;
            ca_we     <= 1'b0;
            ov_out    <= '0;
            ov_we     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            res_we    <= in_valid & wr.res_we;
            cr0_we    <= in_valid & wr.cr0_we;
            so_we     <= in_valid & wr.so_we;
            ca_we     <= in_valid & wr.ca_we;
            ov_we     <= in_valid & wr.ov_we;
            if (in_valid) begin
                res    <= sum;
                cr0    <= wr.cr0;
                so_out <= wr.so;
                ca_out <= {wr.ca, wr.ca32};
                ov_out <= {wr.ov, wr.ov32};
            end
        end
    end
endmodule

// File: rtl/addx_unit_chk.sv
`timescale 1ns/1ps
module addx_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] op,
    input logic       oe,
    input logic       rc,
    input logic       so_in,
    input logic       out_valid,
    input logic       res_we,
    input logic       cr0_we,
    input logic       so_out,
    input logic       so_we,
    input logic       ca_we,
    input logic [1:0] ov_out,
    input logic       ov_we
);
    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid)); // R1

    AST_IDLE_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(res_we | cr0_we | so_we | ca_we | ov_we)); // R12

    AST_SO_FOLLOWS_OV: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> so_we == ov_we); // R7

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        so_we |-> so_out == ($past(so_in) | ov_out[1])); // R7

    AST_OE_GATES_OV: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(oe) && $past(op) < 3'd6) |-> !ov_we && !so_we); // R5

    AST_OVC_WRITES_OV: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd6) |-> ov_we && !ca_we); // R6

    AST_CMP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd7) |-> !(so_we | ov_we | ca_we | res_we) && cr0_we); // R9

    AST_RC_OFF: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rc) && $past(op) != 3'd7) |-> !cr0_we); // R8
endmodule

bind addx_unit addx_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .oe        (oe),
    .rc        (rc),
    .so_in     (so_in),
    .out_valid (out_valid),
    .res_we    (res_we),
    .cr0_we    (cr0_we),
    .so_out    (so_out),
    .so_we     (so_we),
    .ca_we     (ca_we),
    .ov_out    (ov_out),
    .ov_we     (ov_we)
);

// File: tb/addx_unit_test.sv
`timescale 1ns/1ps
module addx_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic        oe = 1'b0, rc = 1'b0, so_in = 1'b0, ca_in = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid, res_we, cr0_we, so_out, so_we, ca_we, ov_we;
    logic [63:0] res;
    logic [3:0]  cr0;
    logic [1:0]  ca_out, ov_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    addx_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .oe(oe), .rc(rc),
        .opa(opa), .opb(opb), .so_in(so_in), .ca_in(ca_in),
        .out_valid(out_valid), .res(res), .res_we(res_we), .cr0(cr0),
        .cr0_we(cr0_we), .so_out(so_out), .so_we(so_we), .ca_out(ca_out),
        .ca_we(ca_we), .ov_out(ov_out), .ov_we(ov_we)
    );

    typedef struct packed {
        logic [63:0] res;
        logic        res_we;
        logic [3:0]  cr0;
        logic        cr0_we;
        logic        so;
        logic        so_we;
        logic [1:0]  ca;
        logic        ca_we;
        logic [1:0]  ov;
        logic        ov_we;
    } exp_t;

    function automatic exp_t model(input logic [2:0] c, input logic e, input logic r,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic s, input logic ci);
        exp_t        m;
        logic [63:0] xx, yy, sm;
        logic        cc;
        logic [64:0] s65;
        logic [32:0] s33;
        logic        ovs, ov32s;
        m  = '0;
        xx = a; yy = b; cc = 1'b0;
        case (c)
            3'd2, 3'd6: cc = ci;
            3'd3, 3'd4: begin xx = ~a; cc = 1'b1; end
            3'd5:       begin xx = ~a; yy = '0; cc = 1'b1; end
            default:    ;
        endcase
        s65   = {1'b0, xx} + {1'b0, yy} + {64'd0, cc};
        s33   = {1'b0, xx[31:0]} + {1'b0, yy[31:0]} + {32'd0, cc};
        sm    = s65[63:0];
        ovs   = (xx[63] == yy[63]) && (sm[63] != xx[63]);
        ov32s = (xx[31] == yy[31]) && (sm[31] != xx[31]);
        if (c == 3'd7) begin
            m.cr0_we = 1'b1;
            m.cr0 = {$signed(a) < $signed(b), $signed(a) > $signed(b), a == b, s};
            return m;
        end
        m.res = sm; m.res_we = 1'b1;
        m.ca_we = (c == 3'd1) || (c == 3'd2) || (c == 3'd4);
        m.ca = {s65[64], s33[32]};
        if (c == 3'd6) begin
            m.ov_we = 1'b1; m.ov = {s65[64], s33[32]};
        end else if (e) begin
            m.ov_we = 1'b1; m.ov = {ovs, ov32s};
        end
        m.so_we = m.ov_we;
        m.so = s | (m.ov_we & m.ov[1]);
        m.cr0_we = r;
        m.cr0 = {sm[63], !sm[63] && sm != 0, sm == 0, m.so_we ? m.so : s};
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic run_one(input logic [2:0] c, input logic e, input logic r,
                           input logic [63:0] a, input logic [63:0] b,
                           input logic s, input logic ci, input string req);
        exp_t m;
        m = model(c, e, r, a, b, s, ci);
        @(negedge clk);
        in_valid = 1'b1; op = c; oe = e; rc = r; opa = a; opb = b; so_in = s; ca_in = ci;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, req, "out_valid R1", 64'(out_valid), 64'd1);
        check(res_we == m.res_we, req, "res_we R1", 64'(res_we), 64'(m.res_we));
        if (m.res_we) check(res == m.res, req, "res R1", res, m.res);
        check(ca_we == m.ca_we, req, "ca_we R3", 64'(ca_we), 64'(m.ca_we));
        if (m.ca_we) check(ca_out == m.ca, req, "ca R3", 64'(ca_out), 64'(m.ca));
        check(ov_we == m.ov_we, req, "ov_we R4/R5/R6", 64'(ov_we), 64'(m.ov_we));
        if (m.ov_we) check(ov_out == m.ov, req, "ov R4/R6", 64'(ov_out), 64'(m.ov));
        check(so_we == m.so_we, req, "so_we R7", 64'(so_we), 64'(m.so_we));
        if (m.so_we) check(so_out == m.so, req, "so R7", 64'(so_out), 64'(m.so));
        check(cr0_we == m.cr0_we, req, "cr0_we R8/R9", 64'(cr0_we), 64'(m.cr0_we));
        if (m.cr0_we) check(cr0 == m.cr0, req, "cr0 R8/R9", 64'(cr0), 64'(m.cr0));
        @(negedge clk);
        check(!(res_we | cr0_we | so_we | ca_we | ov_we | out_valid), "R12",
              "idle enables", 64'({res_we, cr0_we, so_we, ca_we, ov_we, out_valid}), 64'd0);
    endtask

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!(out_valid | res_we | cr0_we | so_we | ca_we | ov_we) && res == 0 &&
              cr0 == 0 && !so_out && ca_out == 0 && ov_out == 0,
              "R11", "reset state", res, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // directed corners
        run_one(3'd0, 1, 1, MAXP, 64'd1, 0, 0, "R4 add overflow 64");
        run_one(3'd0, 1, 1, 64'h7FFF_FFFF, 64'd1, 0, 0, "R4 add overflow 32 only");
        run_one(3'd1, 0, 0, ONES, 64'd1, 0, 0, "R3 carry out 64");
        run_one(3'd1, 0, 1, 64'hFFFF_FFFF, 64'd1, 1, 0, "R3 carry out 32 only");
        run_one(3'd2, 1, 1, ONES, 64'd0, 0, 1, "R2 add with carry-in");
        run_one(3'd3, 1, 1, 64'd5, 64'd5, 0, 0, "R1 rsub equal");
        run_one(3'd4, 0, 1, 64'd7, 64'd3, 0, 0, "R3 rsub borrow");
        run_one(3'd5, 1, 1, MINN, 64'hDEAD_BEEF, 0, 1, "R10 negate min");
        run_one(3'd5, 0, 1, 64'd9, ONES, 1, 1, "R10 negate ignores B/carry");
        run_one(3'd6, 0, 1, ONES, 64'd1, 0, 1, "R6 ovc carry out");
        run_one(3'd6, 1, 0, 64'd1, 64'd2, 1, 0, "R6 ovc no carry, so kept");
        run_one(3'd0, 0, 1, MAXP, MAXP, 1, 0, "R5 oe off");
        run_one(3'd0, 1, 0, MAXP, MAXP, 1, 0, "R8 rc off");
        run_one(3'd7, 1, 1, MINN, 64'd1, 1, 1, "R9 cmp lt");
        run_one(3'd7, 1, 0, 64'd3, ONES, 0, 0, "R9 cmp gt");
        run_one(3'd7, 0, 0, 64'd42, 64'd42, 1, 0, "R9 cmp eq");
        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (($urandom % 4) == 0) a = {a[63], {31{a[62]}}, a[31:0]};
            if (($urandom % 4) == 0) b = ~a + 64'(($urandom % 3));
            run_one(3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2), a, b,
                    1'($urandom % 2), 1'($urandom % 2), "R1 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        #3_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule